// File: doc/BRIEF.md
# Instruction Class Decoder with Skip Condition

This block is purely combinational. It reads the 8-bit instruction word held in the instruction register and sorts it into one of six instruction classes: two-address, memory-reference, one-address ALU, shift, return or conditional skip. Any code that belongs to no class raises an illegal flag instead of a class flag. The sequencing controller and the clock-enable logic need to know about a few particular instructions, so the block also raises a separate flag for each of them: register move, compare, store, jump, call and return.

Skip instructions carry three condition bits. Two of them each enable one flag test: the accumulator sign bit and the carry flag. The enabled tests are ORed. The third bit inverts the combined result. The block turns these into a single skip-taken output, which the controller uses to decide whether the program counter advances past the next word.

Classes are assigned by prefix. Bit 7 low marks a two-address word, and the 1-prefixed space is split among the remaining classes. Several code ranges stay unassigned so the instruction set can grow later. Register-designator extraction and state sequencing belong to other blocks.

Top module: `instr_class_decoder`

## Requirements
- R1: An instruction word with bit 7 = 0 raises `cls_two_addr`. Bits 6..4 are the ALU function code, for example 011 = add and 111 = add with carry.
- R2: For every input, exactly one signal among the six class flags and `illegal` is high.
- R3: The pattern 10 oo mm rr is memory-reference, with oo the opcode and mm the addressing mode. Modes 00 (immediate), 01 (indirect) and 10 (double indirect) raise `cls_mem_ref`. Mode 11 raises `illegal`.
- R4: 1100xxxx raises `cls_alu1` and 1101xxxx raises `cls_shift`.
- R5: 111000xx raises `cls_return` and `op_retn`.
- R6: The codes 111001xx, 111010xx, 111011xx and 11111xxx raise `illegal` and no class flag.
- R7: `op_move` is high only for a two-address word with function code 000. `op_cmpr` is high only for a two-address word with function code 110.
- R8: `op_store`, `op_jump` and `op_call` are high only for a legal memory-reference word with opcode 01, 10 or 11 respectively. Opcode 00 (load) raises none of them.
- R9: For a skip word 11110 v s c, `skip_taken` = v XOR ((s AND `a_sign`) OR (c AND `carry`)).
- R10: `skip_taken` is low for every non-skip word, whatever `a_sign` and `carry` are.
- R11: The class, illegal and special-instruction flags depend on the instruction word only. Changing `a_sign` or `carry` leaves all of them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ir_word | input | 8 | Instruction register contents |
| a_sign | input | 1 | Accumulator most significant bit |
| carry | input | 1 | Carry flag |
| cls_two_addr | output | 1 | Two-address class |
| cls_mem_ref | output | 1 | Memory-reference class (legal mode) |
| cls_alu1 | output | 1 | One-address ALU class |
| cls_shift | output | 1 | Shift class |
| cls_return | output | 1 | Return class |
| cls_skip | output | 1 | Conditional skip class |
| op_move | output | 1 | Register move instruction |
| op_cmpr | output | 1 | Compare instruction |
| op_store | output | 1 | Store instruction |
| op_jump | output | 1 | Jump instruction |
| op_call | output | 1 | Subroutine call instruction |
| op_retn | output | 1 | Subroutine return instruction |
| skip_taken | output | 1 | Skip condition satisfied |
| illegal | output | 1 | Unassigned instruction code |

## Verification
The block holds no state, so a wrong decode appears at the ports in the same evaluation as the instruction word that causes it. It shows up in one of three ways: a class flag with no partner, two flags high together, or a special flag raised outside its class. A mistake in the skip network shows only for particular combinations of the condition bits, the sign bit and the carry. For that reason the bench visits every instruction word under all four flag settings, and checks each result against a model written from the requirements.

// File: rtl/idec_pkg.sv
package idec_pkg;

   localparam int unsigned IDEC_IR_W      = 8;
   localparam int unsigned IDEC_NUM_CLASS = 6;

   // instruction class, value 0 means no class (illegal)
   typedef enum logic [2:0] {
      ICL_NONE  = 3'd0,
      ICL_TWO   = 3'd1,
      ICL_MEM   = 3'd2,
      ICL_ALU1  = 3'd3,
      ICL_SHIFT = 3'd4,
      ICL_RET   = 3'd5,
      ICL_SKIP  = 3'd6
   } iclass_e;

   // bit index of each class in the one-hot class vector
   localparam int unsigned CIX_TWO   = 0;
   localparam int unsigned CIX_MEM   = 1;
   localparam int unsigned CIX_ALU1  = 2;
   localparam int unsigned CIX_SHIFT = 3;
   localparam int unsigned CIX_RET   = 4;
   localparam int unsigned CIX_SKIP  = 5;

endpackage

// File: rtl/idec_class_match.sv
module idec_class_match
   import idec_pkg::*;
#(
   parameter int unsigned IR_W     = IDEC_IR_W,
   parameter int unsigned MODE_W   = 2,
   parameter logic [1:0]  BAD_MODE = 2'b11
) (
   input  logic [IR_W-1:0]           ir,
   output logic [IDEC_NUM_CLASS-1:0] class_hot,
   output logic                      no_class
);

   localparam int unsigned MODE_LSB = 2;

   if (IR_W != 8) begin : g_bad_width
      $error("idec_class_match: IR_W must be 8");
   end
   if (MODE_W != 2) begin : g_bad_mode_w
      $error("idec_class_match: MODE_W must be 2");
   end

   iclass_e cls;
   logic    mode_bad;

   assign mode_bad = (ir[MODE_LSB +: MODE_W] == BAD_MODE);

   always_comb begin
      cls = ICL_NONE;
      casez (ir)
         8'b0???????: cls = ICL_TWO;
         8'b10??????: cls = mode_bad ? ICL_NONE : ICL_MEM;
         8'b1100????: cls = ICL_ALU1;
         8'b1101????: cls = ICL_SHIFT;
         8'b111000??: cls = ICL_RET;
         8'b11110???: cls = ICL_SKIP;
         default:     cls = ICL_NONE;
      endcase
   end

   for (genvar k = 0; k < IDEC_NUM_CLASS; k++) begin : g_hot
      assign class_hot[k] = (cls == iclass_e'(k + 1));
   end

   assign no_class = (cls == ICL_NONE);

endmodule

// File: rtl/idec_special_ops.sv
module idec_special_ops #(
   parameter int unsigned ALU_W    = 3,
   parameter int unsigned MOP_W    = 2,
   parameter logic [2:0]  MOVE_OP  = 3'b000,
   parameter logic [2:0]  CMPR_OP  = 3'b110,
   parameter logic [1:0]  STORE_OP = 2'b01,
   parameter logic [1:0]  JUMP_OP  = 2'b10,
   parameter logic [1:0]  CALL_OP  = 2'b11
) (
   input  logic [ALU_W-1:0] alu_fn,
   input  logic [MOP_W-1:0] mem_op,
   input  logic             is_two,
   input  logic             is_mem,
   input  logic             is_ret,
   output logic             f_move,
   output logic             f_cmpr,
   output logic             f_store,
   output logic             f_jump,
   output logic             f_call,
   output logic             f_retn
);

   if (ALU_W != 3 || MOP_W != 2) begin : g_bad_width
      $error("idec_special_ops: field widths must be 3 and 2");
   end

   assign f_move  = is_two & (alu_fn == MOVE_OP);
   assign f_cmpr  = is_two & (alu_fn == CMPR_OP);
   assign f_store = is_mem & (mem_op == STORE_OP);
   assign f_jump  = is_mem & (mem_op == JUMP_OP);
   assign f_call  = is_mem & (mem_op == CALL_OP);
   assign f_retn  = is_ret;

endmodule

// File: rtl/idec_skip_eval.sv
module idec_skip_eval #(
   parameter int unsigned N_TESTS   = 2,
   parameter bit          INVERT_EN = 1'b1
) (
   input  logic               is_skip,
   input  logic               inv_bit,
   input  logic [N_TESTS-1:0] test_en,
   input  logic [N_TESTS-1:0] status,
   output logic               taken
);

   if (N_TESTS < 1) begin : g_bad_tests
      $error("idec_skip_eval: N_TESTS must be at least 1");
   end

   logic [N_TESTS-1:0] hit;
   logic               any_hit;
   logic               cond;

   for (genvar t = 0; t < N_TESTS; t++) begin : g_test
      assign hit[t] = test_en[t] & status[t];
   end

   assign any_hit = |hit;

   if (INVERT_EN) begin : g_inv
      assign cond = inv_bit ^ any_hit;
   end else begin : g_noinv
      logic unused_inv;
      assign unused_inv = inv_bit;
      assign cond = any_hit;
   end

   assign taken = is_skip & cond;

endmodule

// File: rtl/instr_class_decoder.sv
module instr_class_decoder
   import idec_pkg::*;
#(
   parameter int unsigned IR_W = IDEC_IR_W
) (
   input  logic [IR_W-1:0] ir_word,
   input  logic            a_sign,
   input  logic            carry,
   output logic            cls_two_addr,
   output logic            cls_mem_ref,
   output logic            cls_alu1,
   output logic            cls_shift,
   output logic            cls_return,
   output logic            cls_skip,
   output logic            op_move,
   output logic            op_cmpr,
   output logic            op_store,
   output logic            op_jump,
   output logic            op_call,
   output logic            op_retn,
   output logic            skip_taken,
   output logic            illegal
);

   localparam int unsigned ALU_LSB  = 4;
   localparam int unsigned ALU_W    = 3;
   localparam int unsigned MOP_LSB  = 4;
   localparam int unsigned MOP_W    = 2;
   localparam int unsigned N_TESTS  = 2;
   localparam int unsigned INV_BIT  = N_TESTS;

   if (IR_W != 8) begin : g_bad_width
      $error("instr_class_decoder: IR_W must be 8");
   end

   logic [IDEC_NUM_CLASS-1:0] class_hot;
   logic                      no_class;

   idec_class_match #(
      .IR_W     (IR_W),
      .MODE_W   (2),
      .BAD_MODE (2'b11)
   ) u_match (
      .ir        (ir_word),
      .class_hot (class_hot),
      .no_class  (no_class)
   );

   idec_special_ops #(
      .ALU_W (ALU_W),
      .MOP_W (MOP_W)
   ) u_ops (
      .alu_fn  (ir_word[ALU_LSB +: ALU_W]),
      .mem_op  (ir_word[MOP_LSB +: MOP_W]),
      .is_two  (class_hot[CIX_TWO]),
      .is_mem  (class_hot[CIX_MEM]),
      .is_ret  (class_hot[CIX_RET]),
      .f_move  (op_move),
      .f_cmpr  (op_cmpr),
      .f_store (op_store),
      .f_jump  (op_jump),
      .f_call  (op_call),
      .f_retn  (op_retn)
   );

   // test enable bit 1 selects the sign bit, bit 0 selects carry
   idec_skip_eval #(
      .N_TESTS   (N_TESTS),
      .INVERT_EN (1'b1)
   ) u_skip (
      .is_skip (class_hot[CIX_SKIP]),
      .inv_bit (ir_word[INV_BIT]),
      .test_en (ir_word[N_TESTS-1:0]),
      .status  ({a_sign, carry}),
      .taken   (skip_taken)
   );

   assign cls_two_addr = class_hot[CIX_TWO];
   assign cls_mem_ref  = class_hot[CIX_MEM];
   assign cls_alu1     = class_hot[CIX_ALU1];
   assign cls_shift    = class_hot[CIX_SHIFT];
   assign cls_return   = class_hot[CIX_RET];
   assign cls_skip     = class_hot[CIX_SKIP];
   assign illegal      = no_class;

endmodule

// File: rtl/instr_class_decoder_chk.sv
module instr_class_decoder_chk (
   input logic [7:0] ir_word,
   input logic       a_sign,
   input logic       carry,
   input logic       cls_two_addr,
   input logic       cls_mem_ref,
   input logic       cls_alu1,
   input logic       cls_shift,
   input logic       cls_return,
   input logic       cls_skip,
   input logic       op_move,
   input logic       op_cmpr,
   input logic       op_store,
   input logic       op_jump,
   input logic       op_call,
   input logic       op_retn,
   input logic       skip_taken,
   input logic       illegal
);

   logic unused_in;
   assign unused_in = ^{a_sign, carry};

   always_comb begin
      // R2: one flag among classes and illegal
      a_r2_one_class: assert ($countones({cls_two_addr, cls_mem_ref, cls_alu1,
                                          cls_shift, cls_return, cls_skip,
                                          illegal}) == 1)
         else $error("R2 class flags not exclusive");
      // R1: bit 7 low always means two-address
      a_r1_two_addr: assert (ir_word[7] || cls_two_addr)
         else $error("R1 two-address flag missing");
      // R3: mode 11 under the memory prefix is illegal
      a_r3_bad_mode: assert (!(ir_word[7:6] == 2'b10 && ir_word[3:2] == 2'b11) || illegal)
         else $error("R3 bad mode not illegal");
      // R6: unassigned ranges are illegal
      a_r6_unassigned: assert (!((ir_word[7:4] == 4'hE && ir_word[3:2] != 2'b00) ||
                                 ir_word[7:3] == 5'b11111) || illegal)
         else $error("R6 unassigned code not illegal");
      // R7: move and compare only inside two-address
      a_r7_two_ops: assert (!(op_move || op_cmpr) || cls_two_addr)
         else $error("R7 move/compare outside class");
      // R8: store, jump and call only inside memory-reference
      a_r8_mem_ops: assert ($countones({op_store, op_jump, op_call}) <= 1 &&
                            (!(op_store || op_jump || op_call) || cls_mem_ref))
         else $error("R8 memory op flag outside class");
      // R5: return flag follows return class
      a_r5_retn: assert (op_retn == cls_return)
         else $error("R5 return flag mismatch");
      // R10: skip taken only on skip words
      a_r10_skip_only: assert (!skip_taken || cls_skip)
         else $error("R10 skip taken outside skip class");
   end

endmodule

bind instr_class_decoder instr_class_decoder_chk u_chk (
   .ir_word      (ir_word),
   .a_sign       (a_sign),
   .carry        (carry),
   .cls_two_addr (cls_two_addr),
   .cls_mem_ref  (cls_mem_ref),
   .cls_alu1     (cls_alu1),
   .cls_shift    (cls_shift),
   .cls_return   (cls_return),
   .cls_skip     (cls_skip),
   .op_move      (op_move),
   .op_cmpr      (op_cmpr),
   .op_store     (op_store),
   .op_jump      (op_jump),
   .op_call      (op_call),
   .op_retn      (op_retn),
   .skip_taken   (skip_taken),
   .illegal      (illegal)
);

// File: tb/instr_class_decoder_bench.sv
module instr_class_decoder_bench;

   // result order: two mem alu1 shift ret skip | move cmpr store jump call retn | taken | illegal
   localparam int NV = 22;
   localparam logic [27:0] VEC [0:NV-1] = '{
      {8'h00, 1'b0, 1'b0, 14'b100000_100000_0_0, 4'd7},  // R7 move
      {8'h6A, 1'b0, 1'b0, 14'b100000_010000_0_0, 4'd7},  // R7 compare
      {8'h35, 1'b0, 1'b0, 14'b100000_000000_0_0, 4'd1},  // R1 add
      {8'h7F, 1'b1, 1'b1, 14'b100000_000000_0_0, 4'd1},  // R1 add with carry
      {8'h80, 1'b0, 1'b0, 14'b010000_000000_0_0, 4'd3},  // R3 load immediate
      {8'h95, 1'b0, 1'b0, 14'b010000_001000_0_0, 4'd8},  // R8 store indirect
      {8'hA9, 1'b0, 1'b0, 14'b010000_000100_0_0, 4'd8},  // R8 jump double indirect
      {8'hB2, 1'b0, 1'b0, 14'b010000_000010_0_0, 4'd8},  // R8 call immediate
      {8'hBC, 1'b0, 1'b0, 14'b000000_000000_0_1, 4'd3},  // R3 bad mode
      {8'hC7, 1'b0, 1'b0, 14'b001000_000000_0_0, 4'd4},  // R4 one-address alu
      {8'hD2, 1'b0, 1'b0, 14'b000100_000000_0_0, 4'd4},  // R4 shift
      {8'hE3, 1'b1, 1'b1, 14'b000010_000001_0_0, 4'd5},  // R5 return, R10
      {8'hE4, 1'b0, 1'b0, 14'b000000_000000_0_1, 4'd6},  // R6
      {8'hEF, 1'b0, 1'b0, 14'b000000_000000_0_1, 4'd6},  // R6
      {8'hF8, 1'b1, 1'b1, 14'b000000_000000_0_1, 4'd6},  // R6
      {8'hF2, 1'b1, 1'b0, 14'b000001_000000_1_0, 4'd9},  // R9 sign test
      {8'hF1, 1'b1, 1'b0, 14'b000001_000000_0_0, 4'd9},  // R9 carry masked
      {8'hF3, 1'b0, 1'b1, 14'b000001_000000_1_0, 4'd9},  // R9 carry test
      {8'hF5, 1'b1, 1'b0, 14'b000001_000000_1_0, 4'd9},  // R9 inverted carry
      {8'hF0, 1'b1, 1'b1, 14'b000001_000000_0_0, 4'd9},  // R9 no tests
      {8'hF4, 1'b0, 1'b0, 14'b000001_000000_1_0, 4'd9},  // R9 invert only
      {8'hF7, 1'b1, 1'b1, 14'b000001_000000_0_0, 4'd9}   // R9 both inverted
   };

   logic       clk;
   logic       rst_n;
   logic [7:0] ir_word;
   logic       a_sign;
   logic       carry;
   logic [13:0] dut_out;
   int         checks;
   int         errors;
   bit         done;

   initial clk = 1'b0;
   always #4 clk = ~clk;

   instr_class_decoder u_instr_class_decoder (
      .ir_word      (ir_word),
      .a_sign       (a_sign),
      .carry        (carry),
      .cls_two_addr (dut_out[13]),
      .cls_mem_ref  (dut_out[12]),
      .cls_alu1     (dut_out[11]),
      .cls_shift    (dut_out[10]),
      .cls_return   (dut_out[9]),
      .cls_skip     (dut_out[8]),
      .op_move      (dut_out[7]),
      .op_cmpr      (dut_out[6]),
      .op_store     (dut_out[5]),
      .op_jump      (dut_out[4]),
      .op_call      (dut_out[3]),
      .op_retn      (dut_out[2]),
      .skip_taken   (dut_out[1]),
      .illegal      (dut_out[0])
   );

   // reference written from the requirement list
   function automatic logic [13:0] model(input logic [7:0] w, input logic s, input logic c);
      logic [13:0] r;
      r = '0;
      if (w[7] == 1'b0) begin
         r[13] = 1'b1;
         r[7]  = (w[6:4] == 3'b000);
         r[6]  = (w[6:4] == 3'b110);
      end else if (w[6] == 1'b0) begin
         if (w[3:2] == 2'b11) r[0] = 1'b1;
         else begin
            r[12] = 1'b1;
            r[5]  = (w[5:4] == 2'b01);
            r[4]  = (w[5:4] == 2'b10);
            r[3]  = (w[5:4] == 2'b11);
         end
      end else if (w[5:4] == 2'b00) r[11] = 1'b1;
      else if (w[5:4] == 2'b01) r[10] = 1'b1;
      else if (w[5:2] == 4'b1000) begin
         r[9] = 1'b1;
         r[2] = 1'b1;
      end else if (w[5:3] == 3'b110) begin
         r[8] = 1'b1;
         r[1] = w[2] ? !((w[1] && s) || (w[0] && c)) : ((w[1] && s) || (w[0] && c));
      end else r[0] = 1'b1;
      return r;
   endfunction

   task automatic check(input string tag, input logic [13:0] exp);
      checks++;
      if (dut_out !== exp) begin
         errors++;
         $display("FAIL %s ir=%h a_sign=%b carry=%b actual=%b expected=%b",
                  tag, ir_word, a_sign, carry, dut_out, exp);
      end
   endtask

   initial begin
      checks = 0;
      errors = 0;
      done = 1'b0;
      rst_n = 1'b0;
      ir_word = 8'h00;
      a_sign = 1'b0;
      carry = 1'b0;
      repeat (3) @(negedge clk);
      #2;
      // reset state: cleared word decodes as move (R7)
      check("R7 reset word", 14'b100000_100000_0_0);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         ir_word = VEC[i][27:20];
         a_sign  = VEC[i][19];
         carry   = VEC[i][18];
         #2;
         check($sformatf("R%0d table %0d", VEC[i][3:0], i), VEC[i][17:4]);
      end

      // exhaustive sweep: R2, R6, R9, R10 across all words and flags
      for (int w = 0; w < 256; w++) begin
         for (int f = 0; f < 4; f++) begin
            @(negedge clk);
            ir_word = 8'(w);
            a_sign  = f[1];
            carry   = f[0];
            #2;
            check("R2 R9 R10 sweep", model(8'(w), f[1], f[0]));
         end
      end

      // R11: flags except skip_taken unchanged when status inputs toggle
      for (int w = 0; w < 256; w += 17) begin
         logic [13:0] first;
         @(negedge clk);
         ir_word = 8'(w);
         a_sign = 1'b0;
         carry = 1'b0;
         #2;
         first = dut_out;
         a_sign = 1'b1;
         carry = 1'b1;
         #1;
         checks++;
         if ({dut_out[13:2], dut_out[0]} !== {first[13:2], first[0]}) begin
            errors++;
            $display("FAIL R11 ir=%h actual=%b expected=%b", ir_word, dut_out, first);
         end
      end

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule